// File: doc/BRIEF.md
# Register-Operate Execution Unit with Sign Flags

This block carries out the three arithmetic and logic operations of a small 16-bit load/store machine: add, bitwise AND and bitwise complement. It keeps eight 16-bit general-purpose registers. It decodes one 16-bit instruction word whenever the execute strobe is high. On the next clock edge it writes the result into the named destination register. On that same edge it records whether the written value is negative, zero or positive.

The second operand of add and AND is picked by one instruction bit. It is either a register or a 5-bit immediate, and the immediate is sign-extended to 16 bits. A combinational debug port lets the surrounding logic, or a test bench, read any register. Fetching instructions, branching and memory access belong to other blocks.

Top module: `opu_core`

## Requirements
- R1: While `rst` is high at a rising clock edge, every register is cleared to 0 and the flags become negative=0, zero=1, positive=0. Reset takes priority over a coincident execute strobe.
- R2: Add in register mode (bits 15:12 = 4'b0001, bit 5 = 0) writes src1 + src2, modulo 2^16. The destination is bits 11:9, src1 is bits 8:6 and src2 is bits 2:0.
- R3: Add in immediate mode (bit 5 = 1) adds the value of bits 4:0, sign-extended to 16 bits, to src1. For example, 5'b11111 adds 16'hFFFF and 5'b10000 adds -16.
- R4: AND (bits 15:12 = 4'b0101) writes the bitwise AND of src1 with src2 (bit 5 = 0) or with the sign-extended immediate (bit 5 = 1).
- R5: Complement (bits 15:12 = 4'b1001) writes the bitwise inverse of src1. Bits 5:0 of the instruction have no effect.
- R6: After every register write, exactly one flag is high. Negative is high when bit 15 of the written value is 1, zero is high when the value is 0, and positive is high otherwise.
- R7: In register mode, instruction bits 4:3 have no effect on the result.
- R8: With the execute strobe low, or with any opcode other than the three above, no register and no flag changes.
- R9: The write takes effect on the rising edge at which the execute strobe is high. Until that edge, the debug port shows the old contents, and source operands are always read before the write. For example, adding to r0 with r0 as destination uses the old r0.
- R10: `dbg_data` shows the current contents of the register selected by `dbg_sel`, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| exec_en | input | 1 | Execute strobe for the instruction on `instr` |
| instr | input | 16 | Instruction word |
| dbg_sel | input | 3 | Register index for the debug read port |
| dbg_data | output | 16 | Contents of the selected register |
| flag_n | output | 1 | Last written value was negative |
| flag_z | output | 1 | Last written value was zero |
| flag_p | output | 1 | Last written value was positive |

## Verification
Two pairs of functions can land on the same clock edge, and each pair is provoked on purpose. In the first, reset and an execute strobe are raised in the same cycle. The bench then reads the destination back as 0 with only the zero flag set, which shows that reset won. In the second, a write to a register falls in the cycle in which the debug port and a source operand read that same register. The bench samples the debug port before the edge and expects the old value, then samples after the edge and expects the new one. Instructions that name the same register as destination and source show that operands are read before the write.

// File: rtl/opu_pkg.sv
package opu_pkg;

    localparam int DATA_W  = 16;
    localparam int REG_CNT = 8;
    localparam int SEL_W   = $clog2(REG_CNT);
    localparam int IMM_W   = 5;

    typedef enum logic [3:0] {
        OPC_ADD = 4'b0001,
        OPC_AND = 4'b0101,
        OPC_NOT = 4'b1001
    } opcode_e;

    typedef enum logic [1:0] {
        K_NONE,
        K_ADD,
        K_AND,
        K_INV
    } op_kind_e;

    typedef struct packed {
        op_kind_e              kind;
        logic [SEL_W-1:0]      dst;
        logic [SEL_W-1:0]      src1;
        logic [SEL_W-1:0]      src2;
        logic                  use_imm;
        logic [DATA_W-1:0]     imm;
    } dec_t;

    typedef struct packed {
        logic n;
        logic z;
        logic p;
    } nzp_t;

    function automatic logic [DATA_W-1:0] sext_imm(input logic [IMM_W-1:0] v);
        return {{(DATA_W-IMM_W){v[IMM_W-1]}}, v};
    endfunction

    function automatic nzp_t classify(input logic [DATA_W-1:0] v);
        nzp_t r;
        r.n = v[DATA_W-1];
        r.z = (v == '0);
        r.p = !v[DATA_W-1] && (v != '0);
        return r;
    endfunction

endpackage

// File: rtl/opu_decode.sv
module opu_decode
    import opu_pkg::*;
(
    input  logic [DATA_W-1:0] instr,
    output dec_t              dec
);
    logic [3:0] opc;

    assign opc = instr[15:12];

    always_comb begin
        dec.dst     = instr[11:9];
        dec.src1    = instr[8:6];
        dec.src2    = instr[2:0];
        dec.use_imm = instr[5];
        dec.imm     = sext_imm(instr[IMM_W-1:0]);
        case (opc)
            OPC_ADD: dec.kind = K_ADD;
            OPC_AND: dec.kind = K_AND;
            OPC_NOT: dec.kind = K_INV;
            default: dec.kind = K_NONE;
        endcase
    end
endmodule

// File: rtl/opu_regfile.sv
module opu_regfile
    import opu_pkg::*;
#(
    parameter int W = DATA_W,
    parameter int N = REG_CNT,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    input  logic [AW-1:0] ra3,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2,
    output logic [W-1:0]  rd3
);
    logic [N-1:0][W-1:0] q;
    logic [N-1:0]        hit;

    for (genvar i = 0; i < N; i++) begin : g_hit
        assign hit[i] = we && (wa == AW'(i));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (hit[i]) q[i] <= wd;
            end
        end
    end

    assign rd1 = q[ra1];
    assign rd2 = q[ra2];
    assign rd3 = q[ra3];
endmodule

// File: rtl/opu_alu.sv
module opu_alu
    import opu_pkg::*;
(
    input  dec_t              dec,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b_reg,
    output logic              valid,
    output logic [DATA_W-1:0] y
);
    logic [DATA_W-1:0] b;

    assign b = dec.use_imm ? dec.imm : b_reg;

    always_comb begin
        valid = 1'b1;
        case (dec.kind)
            K_ADD:   y = a + b;
            K_AND:   y = a & b;
            K_INV:   y = ~a;
            default: begin
                y     = '0;
                valid = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/opu_flags.sv
module opu_flags
    import opu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] value,
    output nzp_t              cc
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cc <= '{n: 1'b0, z: 1'b1, p: 1'b0};
        end else if (load) begin
            cc <= classify(value);
        end
    end
endmodule

// File: rtl/opu_core.sv
module opu_core
    import opu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              exec_en,
    input  logic [DATA_W-1:0] instr,
    input  logic [SEL_W-1:0]  dbg_sel,
    output logic [DATA_W-1:0] dbg_data,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_p
);
    dec_t              dec;
    logic [DATA_W-1:0] opa;
    logic [DATA_W-1:0] opb;
    logic [DATA_W-1:0] wr_data;
    logic              op_ok;
    logic              wr_en;
    nzp_t              cc;

    opu_decode u_dec (
        .instr (instr),
        .dec   (dec)
    );

    opu_regfile #(.W(DATA_W), .N(REG_CNT)) u_rf (
        .clk (clk),
        .rst (rst),
        .we  (wr_en),
        .wa  (dec.dst),
        .wd  (wr_data),
        .ra1 (dec.src1),
        .ra2 (dec.src2),
        .ra3 (dbg_sel),
        .rd1 (opa),
        .rd2 (opb),
        .rd3 (dbg_data)
    );

    opu_alu u_alu (
        .dec   (dec),
        .a     (opa),
        .b_reg (opb),
        .valid (op_ok),
        .y     (wr_data)
    );

    assign wr_en = exec_en && op_ok;

    opu_flags u_cc (
        .clk   (clk),
        .rst   (rst),
        .load  (wr_en),
        .value (wr_data),
        .cc    (cc)
    );

    assign flag_n = cc.n;
    assign flag_z = cc.z;
    assign flag_p = cc.p;
endmodule

// File: rtl/opu_core_chk.sv
module opu_core_chk
    import opu_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              exec_en,
    input logic [3:0]        opc,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              flag_n,
    input logic              flag_z,
    input logic              flag_p
);
    logic known_op;
    assign known_op = (opc == OPC_ADD) || (opc == OPC_AND) || (opc == OPC_NOT);

    // R1: state directly after a reset cycle
    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (flag_z && !flag_n && !flag_p));

    // R6: one and only one flag
    p_one_flag_r6: assert property (@(posedge clk) disable iff (rst)
        $countones({flag_n, flag_z, flag_p}) == 1);

    // R6: flags follow the value that was written
    p_flag_sign_r6: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (flag_n == $past(wr_data[DATA_W-1])) &&
                  (flag_z == ($past(wr_data) == '0)));

    // R8: idle cycles leave flags alone
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !exec_en |=> $stable({flag_n, flag_z, flag_p}));

    // R8: unknown opcodes leave flags alone
    p_bad_opc_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (exec_en && !known_op) |=> $stable({flag_n, flag_z, flag_p}));

    // R8: a write only happens under a strobe with a known opcode
    p_write_gate_r8: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (exec_en && known_op));
endmodule

bind opu_core opu_core_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .exec_en (exec_en),
    .opc     (instr[15:12]),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .flag_n  (flag_n),
    .flag_z  (flag_z),
    .flag_p  (flag_p)
);

// File: tb/sim_opu_core.sv
module sim_opu_core;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        exec_en = 1'b0;
    logic [15:0] instr = '0;
    logic [2:0]  dbg_sel = '0;
    logic [15:0] dbg_data;
    logic        flag_n, flag_z, flag_p;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    opu_core u0 (
        .clk(clk), .rst(rst), .exec_en(exec_en), .instr(instr),
        .dbg_sel(dbg_sel), .dbg_data(dbg_data),
        .flag_n(flag_n), .flag_z(flag_z), .flag_p(flag_p)
    );

    function automatic logic [15:0] e_add_r(input logic [2:0] d, s1, s2, input logic [1:0] junk);
        return {4'b0001, d, s1, 1'b0, junk, s2};
    endfunction
    function automatic logic [15:0] e_add_i(input logic [2:0] d, s1, input logic [4:0] im);
        return {4'b0001, d, s1, 1'b1, im};
    endfunction
    function automatic logic [15:0] e_and_r(input logic [2:0] d, s1, s2);
        return {4'b0101, d, s1, 3'b000, s2};
    endfunction
    function automatic logic [15:0] e_and_i(input logic [2:0] d, s1, input logic [4:0] im);
        return {4'b0101, d, s1, 1'b1, im};
    endfunction
    function automatic logic [15:0] e_not(input logic [2:0] d, s1, input logic [5:0] low);
        return {4'b1001, d, s1, low};
    endfunction

    task automatic run(input logic [15:0] w);
        @(negedge clk);
        instr = w;
        exec_en = 1'b1;
        @(negedge clk);
        exec_en = 1'b0;
        #1;
    endtask

    task automatic chk_reg(input int idx, input logic [15:0] exp, input string tag);
        dbg_sel = idx[2:0];
        #1;
        total++;
        if (dbg_data !== exp) begin
            bad++;
            $display("FAIL %s: r%0d actual=%h expected=%h", tag, idx, dbg_data, exp);
        end
    endtask

    task automatic chk_cc(input logic n, z, p, input string tag);
        total++;
        if ({flag_n, flag_z, flag_p} !== {n, z, p}) begin
            bad++;
            $display("FAIL %s: nzp actual=%b expected=%b", tag,
                     {flag_n, flag_z, flag_p}, {n, z, p});
        end
    endtask

    task automatic t_reset;
        for (int i = 0; i < 8; i++) chk_reg(i, 16'h0000, "R1 reset clears");
        chk_cc(0, 1, 0, "R1 reset flags");
    endtask

    task automatic t_counting;
        run(e_and_i(3'd0, 3'd0, 5'd0));
        chk_reg(0, 16'h0000, "R4 and imm zero");
        chk_cc(0, 1, 0, "R6 zero flag");
        run(e_add_i(3'd0, 3'd0, 5'd7));
        chk_reg(0, 16'h0007, "R3 add imm 7");
        chk_cc(0, 0, 1, "R6 positive flag");
        run(e_and_i(3'd1, 3'd1, 5'd0));
        run(e_add_i(3'd1, 3'd1, 5'd5));
        chk_reg(1, 16'h0005, "R3 add imm 5");
        for (int k = 0; k < 6; k++) run(e_add_i(3'd0, 3'd0, 5'b11111));
        chk_reg(0, 16'h0001, "R9 self update decrement");
        chk_cc(0, 0, 1, "R6 still positive");
        run(e_add_i(3'd0, 3'd0, 5'b11111));
        chk_reg(0, 16'h0000, "R3 minus one to zero");
        chk_cc(0, 1, 0, "R6 zero after decrement");
    endtask

    task automatic t_add_modes;
        run(e_add_i(3'd2, 3'd1, 5'b10000));
        chk_reg(2, 16'hFFF5, "R3 imm -16");
        chk_cc(1, 0, 0, "R6 negative flag");
        run(e_add_r(3'd3, 3'd2, 3'd1, 2'b00));
        chk_reg(3, 16'hFFFA, "R2 add reg");
        chk_cc(1, 0, 0, "R6 negative after reg add");
        run(e_add_r(3'd4, 3'd1, 3'd1, 2'b11));
        chk_reg(4, 16'h000A, "R7 bits 4:3 ignored");
        chk_cc(0, 0, 1, "R7 flags");
        run(e_add_r(3'd5, 3'd3, 3'd4, 2'b00));
        chk_reg(5, 16'h0004, "R2 wraps modulo 2^16");
    endtask

    task automatic t_and_not;
        run(e_and_r(3'd5, 3'd3, 3'd4));
        chk_reg(5, 16'h000A, "R4 and reg");
        run(e_and_i(3'd6, 3'd2, 5'b11111));
        chk_reg(6, 16'hFFF5, "R4 and imm -1 sign extended");
        chk_cc(1, 0, 0, "R6 negative after and");
        run(e_and_i(3'd6, 3'd6, 5'b01100));
        chk_reg(6, 16'h0004, "R4 and imm 12");
        run(e_not(3'd7, 3'd6, 6'b111111));
        chk_reg(7, 16'hFFFB, "R5 complement");
        chk_cc(1, 0, 0, "R6 negative after complement");
        run(e_not(3'd7, 3'd2, 6'b000000));
        chk_reg(7, 16'h000A, "R5 low bits ignored");
        chk_cc(0, 0, 1, "R6 positive after complement");
    endtask

    task automatic t_no_effect;
        @(negedge clk);
        instr = e_add_i(3'd0, 3'd0, 5'd7);
        exec_en = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk_reg(0, 16'h0000, "R8 no strobe no write");
        chk_cc(0, 0, 1, "R8 no strobe flags held");
        run({4'b0000, 3'd0, 3'd0, 1'b1, 5'd3});
        chk_reg(0, 16'h0000, "R8 unknown opcode no write");
        chk_cc(0, 0, 1, "R8 unknown opcode flags held");
        run({4'b1111, 3'd1, 3'd1, 6'd0});
        chk_reg(1, 16'h0005, "R8 opcode 1111 no write");
    endtask

    task automatic t_same_cycle_read;
        @(negedge clk);
        instr = e_add_i(3'd0, 3'd1, 5'd0);
        exec_en = 1'b1;
        dbg_sel = 3'd0;
        #1;
        total++;
        if (dbg_data !== 16'h0000) begin
            bad++;
            $display("FAIL R9 before edge: actual=%h expected=%h", dbg_data, 16'h0000);
        end
        @(negedge clk);
        exec_en = 1'b0;
        #1;
        chk_reg(0, 16'h0005, "R10 debug after edge");
        chk_cc(0, 0, 1, "R6 after copy");
    endtask

    task automatic t_reset_vs_exec;
        @(negedge clk);
        rst = 1'b1;
        instr = e_add_i(3'd1, 3'd1, 5'd1);
        exec_en = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        exec_en = 1'b0;
        #1;
        chk_reg(1, 16'h0000, "R1 reset beats strobe");
        chk_cc(0, 1, 0, "R1 reset beats strobe flags");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_counting();
        t_add_modes();
        t_and_not();
        t_no_effect();
        t_same_cycle_read();
        t_reset_vs_exec();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule